// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is an SPI master that walks a conversion scan across the inputs of a serial SAR converter. The converter exchanges 16-bit words and works in manual mode. A one-cycle `start` pulse captures a channel enable mask. The block then sends one conversion command for each enabled channel, lowest index first. Two all-zero flush words follow. The block produces the serial clock, the chip select framing and the command data on its own.

The converter answers each command two words late. The block therefore keeps a short record of what it asked for and pairs each returned word with the channel it requested two frames earlier. Each returned word carries a 4-bit channel tag. The block compares that tag against the expected channel and delivers the sample on a simple valid-qualified stream, with the channel number and a mismatch flag. A `done` pulse closes each scan.

Top module: `adc_scan_seq`

## Requirements
- R1: Each SPI word is 16 bits, sent MSB first in mode 0. SCLK idles low and `spi_mosi` changes only on falling SCLK edges. `spi_miso` is sampled on rising edges. Each SCLK half-period lasts CLK_DIV clock cycles. Chip select is low for exactly one word and stays high for at least 2*CLK_DIV clock cycles between words.
- R2: A conversion command word has bit 12 set and the channel number in bits 10:7. All other bits are zero.
- R3: One command is issued for each set bit of the mask, in ascending channel order. Disabled channels get no command.
- R4: After the last command, exactly two all-zero words are sent, so a scan with P enabled channels is P+2 words long.
- R5: The word returned during frame k belongs to the command of frame k-2. Replies in the first two frames are discarded. Exactly one sample is emitted per enabled channel, in ascending order. `smp_chan` carries the channel that was commanded, not the returned tag.
- R6: `smp_data` equals returned bits 11 down to 12-RES_BITS.
- R7: `smp_err` is 1 exactly when returned bits 15:12 differ from the commanded channel.
- R8: A start with an all-zero mask gives a `done` pulse on the next cycle. It causes no chip-select activity, and `busy` stays low.
- R9: A `start` pulse that arrives while `busy` is high has no effect. The scan in progress is unchanged, and no second scan follows it.
- R10: `done` is a one-cycle pulse in the cycle after the last sample of a non-empty scan. `busy` is low in that cycle.
- R11: After reset, `busy`, `done` and `smp_valid` are 0, `spi_cs_n` is 1 and `spi_sclk` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a scan |
| ch_mask | input | NUM_CH | Channel enable mask, captured at start |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select, framed per word |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Result data from the converter |
| smp_valid | output | 1 | Sample strobe |
| smp_chan | output | 4 | Channel the sample belongs to |
| smp_data | output | RES_BITS | Sample value |
| smp_err | output | 1 | Returned channel tag mismatch |

## Verification
The hardest case to reach is a reply whose tag disagrees with the command two frames back. A correct converter never sends one. The bench therefore models the converter so that it answers each command two frames late, and a per-channel corruption mask flips the tag for selected channels. The first two frames return a fixed garbage pattern, which the block must discard. All sixteen masks of a four-channel configuration are swept, and each pass uses different sample values. A second start with a different mask is injected in the middle of a scan to show that it is ignored.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int WORD_W  = 16;
  localparam int TAG_W   = 4;
  localparam int ARM_BIT = 12;
  localparam int SEL_LSB = 7;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] ch;
  } slot_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_FIN} sq_state_t;
  typedef enum logic [1:0] {E_IDLE, E_LEAD, E_XFER, E_GAP} eng_state_t;

  // Manual-mode conversion request for one channel.
  function automatic logic [WORD_W-1:0] mk_cmd(input logic [TAG_W-1:0] ch);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ARM_BIT] = 1'b1;
    w[SEL_LSB +: TAG_W] = ch;
    return w;
  endfunction

  // Channel tag carried in the top nibble of a reply.
  function automatic logic [TAG_W-1:0] tag_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: TAG_W];
  endfunction

endpackage

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import adc_scan_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] tx_word,
  output logic              ready,
  output logic              word_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] HLAST = DIV_W'(CLK_DIV - 1);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0] BITS_FULL = BIT_W'(WORD_W);

  eng_state_t        st;
  logic [DIV_W-1:0]  hcnt;
  logic [BIT_W-1:0]  bits;
  logic              gap_half;
  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic              tick;

  assign tick    = (hcnt == HLAST);
  assign ready   = (st == E_IDLE);
  assign mosi    = tx_sh[WORD_W-1];
  assign rx_word = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      hcnt      <= '0;
      bits      <= '0;
      gap_half  <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sclk      <= 1'b0;
      cs_n      <= 1'b1;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      case (st)
        E_IDLE: begin
          hcnt <= '0;
          if (go) begin
            tx_sh <= tx_word;
            cs_n  <= 1'b0;
            st    <= E_LEAD;
          end
        end
        E_LEAD: begin
          if (tick) begin
            hcnt  <= '0;
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[WORD_W-2:0], miso};
            bits  <= BIT_W'(1);
            st    <= E_XFER;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        E_XFER: begin
          if (tick) begin
            hcnt <= '0;
            if (sclk) begin
              sclk <= 1'b0;
              if (bits == BITS_FULL) begin
                cs_n      <= 1'b1;
                word_done <= 1'b1;
                gap_half  <= 1'b0;
                st        <= E_GAP;
              end else begin
                tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
              end
            end else begin
              sclk  <= 1'b1;
              rx_sh <= {rx_sh[WORD_W-2:0], miso};
              bits  <= bits + 1'b1;
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: begin
          if (tick) begin
            hcnt <= '0;
            if (gap_half) st <= E_IDLE;
            else          gap_half <= 1'b1;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/scan_pick.sv
module scan_pick
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CUR_W  = $clog2(NUM_CH + 1)
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CUR_W-1:0]  from,
  output logic              found,
  output logic [TAG_W-1:0]  idx
);

  logic [NUM_CH-1:0] cand;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cand
    assign cand[g] = mask[g] && (from <= CUR_W'(g));
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = TAG_W'(i);
      end
    end
  end

endmodule

// File: rtl/reply_align.sv
module reply_align
  import adc_scan_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  shift,
  input  slot_t new_slot,
  output slot_t due_slot
);

  slot_t q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (clear) begin
        q[g] <= '0;
      end else if (shift) begin
        if (g == 0) q[g] <= new_slot;
        else        q[g] <= q[(g > 0) ? g - 1 : 0];
      end
    end
  end

  assign due_slot = q[LAT-1];

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12,
  parameter int CLK_DIV  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NUM_CH-1:0]   ch_mask,
  output logic                busy,
  output logic                done,
  output logic                spi_sclk,
  output logic                spi_cs_n,
  output logic                spi_mosi,
  input  logic                spi_miso,
  output logic                smp_valid,
  output logic [TAG_W-1:0]    smp_chan,
  output logic [RES_BITS-1:0] smp_data,
  output logic                smp_err
);

  localparam int CUR_W     = $clog2(NUM_CH + 1);
  localparam int REPLY_LAT = 2;
  localparam int DATA_MSB  = WORD_W - TAG_W - 1;

  sq_state_t         st;
  logic [NUM_CH-1:0] mask_r;
  logic [CUR_W-1:0]  cursor;
  logic [1:0]        flush_cnt;
  slot_t             cur_slot;
  slot_t             due_slot;
  logic              pk_found;
  logic [TAG_W-1:0]  pk_idx;
  logic              eng_ready;
  logic [WORD_W-1:0] tx_word;
  logic [WORD_W-1:0] rx_word;

  // Named internal events for the checker.
  logic issue_evt;
  logic word_done;
  logic accept_evt;

  assign busy       = (st != SQ_IDLE);
  assign accept_evt = (st == SQ_IDLE) && start && (|ch_mask);
  assign issue_evt  = (st == SQ_ISSUE) && eng_ready;
  assign tx_word    = pk_found ? mk_cmd(pk_idx) : '0;

  scan_pick #(.NUM_CH(NUM_CH), .CUR_W(CUR_W)) u_pick (
    .mask  (mask_r),
    .from  (cursor),
    .found (pk_found),
    .idx   (pk_idx)
  );

  spi_word_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (issue_evt),
    .tx_word   (tx_word),
    .ready     (eng_ready),
    .word_done (word_done),
    .rx_word   (rx_word),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .miso      (spi_miso)
  );

  reply_align #(.LAT(REPLY_LAT)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept_evt),
    .shift    (word_done),
    .new_slot (cur_slot),
    .due_slot (due_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      mask_r    <= '0;
      cursor    <= '0;
      flush_cnt <= '0;
      cur_slot  <= '0;
      done      <= 1'b0;
      smp_valid <= 1'b0;
      smp_chan  <= '0;
      smp_data  <= '0;
      smp_err   <= 1'b0;
    end else begin
      done      <= 1'b0;
      smp_valid <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start) begin
            if (|ch_mask) begin
              mask_r    <= ch_mask;
              cursor    <= '0;
              flush_cnt <= '0;
              st        <= SQ_ISSUE;
            end else begin
              done <= 1'b1;
            end
          end
        end
        SQ_ISSUE: begin
          if (issue_evt) begin
            st <= SQ_WAIT;
            if (pk_found) begin
              cur_slot <= '{vld: 1'b1, ch: pk_idx};
              cursor   <= CUR_W'(pk_idx) + 1'b1;
            end else begin
              cur_slot  <= '0;
              flush_cnt <= flush_cnt + 1'b1;
            end
          end
        end
        SQ_WAIT: begin
          if (word_done) begin
            if (due_slot.vld) begin
              smp_valid <= 1'b1;
              smp_chan  <= due_slot.ch;
              smp_data  <= rx_word[DATA_MSB -: RES_BITS];
              smp_err   <= (tag_of(rx_word) != due_slot.ch);
            end
            st <= (flush_cnt == 2'd2) ? SQ_FIN : SQ_ISSUE;
          end
        end
        default: begin
          done <= 1'b1;
          st   <= SQ_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic spi_mosi,
  input logic smp_valid,
  input logic word_done,
  input logic issue_evt
);

  // R1: serial clock is parked low whenever no word is framed
  a_r1_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R1: transmit data holds across every rising serial clock edge
  a_r1_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));

  // R1: chip select never pulses high for a single cycle
  a_r1_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  // R3: a new word starts only while the bus is unframed
  a_r3_issue_unframed: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |-> (spi_cs_n && busy));

  // R5: a sample only follows a completed word
  a_r5_sample_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(word_done));

  // R8: an idle sequencer leaves chip select high
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  // R10: the end pulse comes out with the sequencer idle
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: done never coincides with a sample
  a_r10_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !smp_valid);

endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .spi_sclk  (spi_sclk),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi),
  .smp_valid (smp_valid),
  .word_done (word_done),
  .issue_evt (issue_evt)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;

  localparam int NUM_CH   = 4;
  localparam int RES_BITS = 10;
  localparam int CLK_DIV  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NUM_CH-1:0] ch_mask = '0;
  logic busy, done, spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic smp_valid, smp_err;
  logic [3:0] smp_chan;
  logic [RES_BITS-1:0] smp_data;

  always #4 clk = ~clk;

  adc_scan_seq #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ch_mask(ch_mask),
    .busy(busy), .done(done), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_data(smp_data), .smp_err(smp_err)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Converter model: answers two frames late, optional tag corruption.
  int widx = 0;
  int cs_falls = 0;
  int pass_id = 0;
  logic [NUM_CH-1:0] corrupt = '0;
  logic [15:0] cmdlog [0:31];
  logic [15:0] resp = '0;
  logic [15:0] cap = '0;

  assign spi_miso = resp[15];

  function automatic logic [11:0] pat(input int ch, input int p);
    return 12'(ch * 173 + p * 59 + 3);
  endfunction

  always @(negedge spi_cs_n) begin
    cs_falls++;
    if (widx >= 2 && widx < 34 && cmdlog[widx-2][12]) begin
      int c;
      logic [3:0] t;
      c = int'(cmdlog[widx-2][10:7]);
      t = 4'(c);
      if (c < NUM_CH && corrupt[c]) t = t ^ 4'h9;
      resp = {t, pat(c, pass_id)};
    end else begin
      resp = 16'hA5A5;
    end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) resp = {resp[14:0], 1'b0};
  always @(posedge spi_sclk) cap = {cap[14:0], spi_mosi};
  always @(posedge spi_cs_n) begin
    if (widx < 32) cmdlog[widx] = cap;
    widx++;
  end

  // Bus timing monitors (R1)
  int hi_run = 0;
  int gap_viol = 0;
  int idle_viol = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n) begin
        hi_run++;
        if (spi_sclk) idle_viol++;
      end else begin
        if (hi_run > 0 && hi_run < 2 * CLK_DIV) gap_viol++;
        hi_run = 0;
      end
    end
  end

  // Output collector
  int n = 0;
  int done_seen = 0;
  int done_cyc = 0;
  int last_v_cyc = 0;
  int busy_at_done = 0;
  int got_ch [0:15];
  int got_dt [0:15];
  int got_er [0:15];
  always @(negedge clk) begin
    if (smp_valid) begin
      if (n < 16) begin
        got_ch[n] = int'(smp_chan);
        got_dt[n] = int'(smp_data);
        got_er[n] = int'(smp_err);
      end
      n++;
      last_v_cyc = cyc;
    end
    if (done) begin
      done_seen++;
      done_cyc = cyc;
      busy_at_done = int'(busy);
    end
  end

  task automatic run_scan(input logic [NUM_CH-1:0] m, input logic [NUM_CH-1:0] cm,
                          input bit poke);
    int st_cyc, pop, waited, falls_end;
    int exp_ch [0:15];
    widx = 0; n = 0; done_seen = 0; corrupt = cm; pass_id++;
    gap_viol = 0; idle_viol = 0;
    @(negedge clk);
    ch_mask = m; start = 1'b1; st_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (100) @(negedge clk);
      ch_mask = ~m; start = 1'b1;
      @(negedge clk);
      start = 1'b0; ch_mask = m;
    end
    waited = 0;
    while (done_seen == 0 && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    falls_end = cs_falls;
    repeat (40) @(negedge clk);
    pop = 0;
    for (int c = 0; c < NUM_CH; c++) if (m[c]) begin exp_ch[pop] = c; pop++; end
    chk(done_seen == 1, "R10 single done pulse", done_seen, 1);
    chk(busy_at_done == 0, "R10 busy low with done", busy_at_done, 0);
    if (pop == 0) begin
      chk(done_cyc == st_cyc + 1, "R8 empty mask done timing", done_cyc, st_cyc + 1);
      chk(widx == 0 && n == 0, "R8 empty mask no SPI", widx, 0);
    end else begin
      chk(widx == pop + 2, "R4 word count", widx, pop + 2);
      for (int i = 0; i < pop; i++)
        chk(cmdlog[i] == (16'h1000 | (16'(exp_ch[i]) << 7)), "R2 R3 command word",
            int'(cmdlog[i]), int'(16'h1000 | (16'(exp_ch[i]) << 7)));
      chk(cmdlog[pop] == 16'h0 && cmdlog[pop+1] == 16'h0, "R4 flush words zero",
          int'(cmdlog[pop]), 0);
      chk(n == pop, "R5 sample count", n, pop);
      for (int i = 0; i < pop && i < n; i++) begin
        int ed;
        ed = int'(pat(exp_ch[i], pass_id) >> (12 - RES_BITS));
        chk(got_ch[i] == exp_ch[i], "R5 sample channel", got_ch[i], exp_ch[i]);
        chk(got_dt[i] == ed, "R6 sample data", got_dt[i], ed);
        chk(got_er[i] == int'(cm[exp_ch[i]]), "R7 tag check", got_er[i], int'(cm[exp_ch[i]]));
      end
      chk(done_cyc == last_v_cyc + 1, "R10 done after last sample", done_cyc, last_v_cyc + 1);
      chk(gap_viol == 0 && idle_viol == 0, "R1 framing", gap_viol + idle_viol, 0);
    end
    chk(cs_falls == falls_end, "R9 no extra scan", cs_falls - falls_end, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && smp_valid == 0, "R11 reset outputs",
        int'({busy, done, smp_valid}), 0);
    chk(spi_cs_n == 1 && spi_sclk == 0, "R11 reset bus", int'({spi_cs_n, spi_sclk}), 2);
    for (int m = 0; m < (1 << NUM_CH); m++) run_scan(NUM_CH'(m), '0, 1'b0);
    run_scan(4'b1111, 4'b0100, 1'b0);
    run_scan(4'b1011, 4'b1001, 1'b0);
    run_scan(4'b0001, 4'b0001, 1'b0);
    run_scan(4'b0101, 4'b0000, 1'b1);
    run_scan(4'b1000, 4'b0000, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule